// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous command port and an external asynchronous static RAM organised as 256K words of 16 bits. A client presents an address, a write flag, per-byte lane selects and write data. The block then drives the memory's active-low select, write strobe, output strobe and per-lane strobes. It paces every cycle with clock-counted waits so that the access time, write-pulse width, data setup and output float delay of the memory are respected.

The shared data pins are modelled as three signals: an outgoing word, an incoming word and an output enable. The sequencer only drives the pins once the memory is guaranteed to have released them. It always releases them before the memory is asked to drive them again. Every access ends with a single-cycle acknowledge; for a read it carries the captured word. The strobe timing is set by parameters so the same logic can be used at any clock rate.

Top module: `asram_bridge`

## Requirements
- R1: While reset is high and just after it, all memory strobes are high, the data output enable is low, `req_ready` is high and `rsp_ack` is low.
- R2: A command is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from that edge until the access has ended, and a command held on the port during that time neither changes the memory pins nor starts a second access.
- R3: A read holds select and output strobe low, with the write strobe high and the address steady, for exactly `RD_CYC` cycles. The read word is the value on `sram_dq_i` at the edge that ends the last of those cycles.
- R4: A write holds select and write strobe low, with the output strobe high, for exactly `WR_CYC` cycles at the address given with the command.
- R5: `sram_dq_oe` goes high only after the write strobe has been low for `DRV_DLY` cycles. It stays high, with the write word unchanged, up to the rise of the write strobe and for `HOLD_CYC` cycles after it. It is never high while the output strobe is low or while the memory may still be driving the pins.
- R6: `req_be` bit 0 selects data bits 7:0 and drives `sram_bl_n` bit 0 low. Bit 1 selects bits 15:8 and drives `sram_bl_n` bit 1 low. A lane whose select is 0 keeps its stored byte on a write, and all lane strobes are high whenever select is high.
- R7: Between two accesses the select strobe stays high for at least `GAP_CYC`+1 cycles. A read that follows a write therefore finds the data pins released.
- R8: `rsp_ack` is high for exactly one cycle per command. For a read it is high in cycle `RD_CYC`+1 after the accepting edge. For a write it is high in cycle `WR_CYC`+`HOLD_CYC`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_be | input | DATA_W/8 | Byte lane selects, bit 0 = low byte |
| req_wdata | input | DATA_W | Write word |
| req_ready | output | 1 | Idle, able to take a command |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Word captured by the last read |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_bl_n | output | DATA_W/8 | Lane strobes, active low, bit 0 = low byte |
| sram_dq_o | output | DATA_W | Word driven onto the data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_i | input | DATA_W | Word read from the data pins |

## Verification
The bench builds the block with a 4 ns clock and with `RD_CYC`=12, `WR_CYC`=13, `DRV_DLY`=5, `HOLD_CYC`=1 and `GAP_CYC`=1. With these values the 45 ns access, 35 ns select-to-write-end, 25 ns data setup and 18 ns float windows span several cycles each. That makes an off-by-one in any count visible to the bench's memory model. The model returns a poison word until its access count has elapsed, and it accepts a write only if the setup and pulse counts were met. It flags contention whenever the drive enable overlaps a cycle in which the memory is, or may still be, driving the pins.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WRITE = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4
  } asram_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // R3/R4: wait counts step down by one each cycle when not reloaded
  a_r3_timer_step: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC   = 5,
  parameter int WR_CYC   = 5,
  parameter int DRV_DLY  = 2,
  parameter int HOLD_CYC = 1,
  parameter int GAP_CYC  = 1,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [CW-1:0] cnt,
  input  logic          cnt_zero,
  output asram_state_e  st,
  output logic          accept,
  output logic          access_end,
  output logic          capture,
  output logic          ack_nxt,
  output logic          drive_nxt,
  output logic          load,
  output logic [CW-1:0] load_val
);

  localparam logic [CW-1:0] RD_LOAD   = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] WR_LOAD   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] GAP_LOAD  = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] DRV_MARK  = CW'(WR_CYC - DRV_DLY);

  asram_state_e st_nxt;

  always_comb begin
    st_nxt     = st;
    accept     = 1'b0;
    access_end = 1'b0;
    capture    = 1'b0;
    ack_nxt    = 1'b0;
    load       = 1'b0;
    load_val   = '0;
    unique case (st)
      ST_IDLE: if (req_valid) begin
        accept   = 1'b1;
        load     = 1'b1;
        st_nxt   = req_write ? ST_WRITE : ST_READ;
        load_val = req_write ? WR_LOAD : RD_LOAD;
      end
      ST_READ: if (cnt_zero) begin
        access_end = 1'b1;
        capture    = 1'b1;
        ack_nxt    = 1'b1;
        load       = 1'b1;
        load_val   = GAP_LOAD;
        st_nxt     = ST_GAP;
      end
      ST_WRITE: if (cnt_zero) begin
        access_end = 1'b1;
        load       = 1'b1;
        load_val   = HOLD_LOAD;
        st_nxt     = ST_HOLD;
      end
      ST_HOLD: if (cnt_zero) begin
        ack_nxt  = 1'b1;
        load     = 1'b1;
        load_val = GAP_LOAD;
        st_nxt   = ST_GAP;
      end
      ST_GAP: if (cnt_zero) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  // data pins driven from cycle DRV_DLY+1 of the write pulse through the hold
  assign drive_nxt = ((st == ST_WRITE) && (cnt <= DRV_MARK)) ||
                     ((st == ST_HOLD) && !cnt_zero);

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  // R2: the timer is idle whenever a command can be accepted
  a_r2_idle_timer_clear: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> cnt_zero);

  // R8: completion leads to the gap state
  a_r8_ack_to_gap: assert property (@(posedge clk) disable iff (rst)
    ack_nxt |=> (st == ST_GAP));

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int RD_CYC   = 5,
  parameter int WR_CYC   = 5,
  parameter int DRV_DLY  = 2,
  parameter int HOLD_CYC = 1,
  parameter int GAP_CYC  = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W/8-1:0]   req_be,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  req_ready,
  output logic                  rsp_ack,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_ce_n,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic [DATA_W/8-1:0]   sram_bl_n,
  output logic [DATA_W-1:0]     sram_dq_o,
  output logic                  sram_dq_oe,
  input  logic [DATA_W-1:0]     sram_dq_i
);

  localparam int LANES = DATA_W / 8;
  localparam int MAXC  = max2(max2(RD_CYC, WR_CYC), max2(HOLD_CYC, GAP_CYC));
  localparam int CW    = $clog2(MAXC + 1);

  asram_state_e  st;
  logic          accept, access_end, capture, ack_nxt, drive_nxt, load;
  logic [CW-1:0] load_val, cnt;
  logic          cnt_zero;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  asram_fsm #(
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .DRV_DLY  (DRV_DLY),
    .HOLD_CYC (HOLD_CYC),
    .GAP_CYC  (GAP_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .cnt        (cnt),
    .cnt_zero   (cnt_zero),
    .st         (st),
    .accept     (accept),
    .access_end (access_end),
    .capture    (capture),
    .ack_nxt    (ack_nxt),
    .drive_nxt  (drive_nxt),
    .load       (load),
    .load_val   (load_val)
  );

  assign req_ready = (st == ST_IDLE);

  // control strobes and address, all registered
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_dq_oe <= 1'b0;
      rsp_ack    <= 1'b0;
    end else begin
      rsp_ack    <= ack_nxt;
      sram_dq_oe <= drive_nxt;
      if (accept) begin
        sram_addr <= req_addr;
        sram_dq_o <= req_wdata;
        sram_ce_n <= 1'b0;
        sram_we_n <= !req_write;
        sram_oe_n <= req_write;
      end else if (access_end) begin
        sram_ce_n <= 1'b1;
        sram_we_n <= 1'b1;
        sram_oe_n <= 1'b1;
      end
    end
  end

  // per-lane strobes and read capture
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic       bl_q;
    logic [7:0] rd_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bl_q <= 1'b1;
        rd_q <= '0;
      end else begin
        if (accept)          bl_q <= !req_be[l];
        else if (access_end) bl_q <= 1'b1;
        if (capture)         rd_q <= sram_dq_i[l*8 +: 8];
      end
    end
    assign sram_bl_n[l]        = bl_q;
    assign rsp_rdata[l*8 +: 8] = rd_q;
  end

  // R5: the controller never drives while the memory output is enabled
  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  // R5: drive begins only after the write strobe has already been low
  a_r5_drive_after_we: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

  // R4: write strobe only with select low and output strobe high
  a_r4_write_strobes: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_ce_n && sram_oe_n));

  // R3: address steady during a read
  a_r3_read_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));

  // R2: an access starts only from an accepted command
  a_r2_start_from_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_ce_n) |-> $past(req_valid && req_ready));

  // R7: select high for at least two cycles before each access
  a_r7_gap_before_access: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_ce_n) |-> ($past(sram_ce_n) && $past(sram_ce_n, 2)));

  // R6: lane strobes idle with select
  a_r6_lanes_idle: assert property (@(posedge clk) disable iff (rst)
    sram_ce_n |-> (&sram_bl_n));

  // R8: acknowledge is a single-cycle pulse
  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    rsp_ack |=> !rsp_ack);

endmodule

// File: tb/asram_bridge_tb.sv
module asram_bridge_tb;

  localparam int AW = 18, DW = 16;
  localparam int RD = 12, WR = 13, DRV = 5, HOLD = 1, GAP = 1;
  localparam int SETUP_CYC = 7;   // 25 ns at 4 ns
  localparam int PULSE_CYC = 9;   // 35 ns
  localparam int ACC_CYC   = 12;  // 45 ns
  localparam int HZ_CYC    = 5;   // 18 ns

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_be = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_ack;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [1:0]    sram_bl_n;
  logic [DW-1:0] sram_dq_o;
  logic [DW-1:0] sram_dq_i = 16'hBAD0;

  asram_bridge #(
    .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WR_CYC(WR),
    .DRV_DLY(DRV), .HOLD_CYC(HOLD), .GAP_CYC(GAP)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_bl_n(sram_bl_n), .sram_dq_o(sram_dq_o),
    .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and golden copy
  logic [DW-1:0] mem  [1024];
  logic [DW-1:0] gold [1024];
  logic          p_ce, p_we, p_dqoe, p_drv;
  logic [1:0]    p_bl;
  logic [AW-1:0] p_addr, last_waddr;
  logic [DW-1:0] p_dq;
  int            dstab, ccnt, hirun, hz, rcnt, n_writes;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i]  = 16'(i * 7 + 3) ^ 16'h5A00;
      gold[i] = 16'(i * 7 + 3) ^ 16'h5A00;
    end
    n_writes = 0;
  end

  always @(negedge clk) begin
    logic drive_now;
    if (rst) begin
      p_ce = 1'b1; p_we = 1'b1; p_dqoe = 1'b0; p_drv = 1'b0;
      p_bl = 2'b11; p_addr = '0; p_dq = '0;
      dstab = 0; ccnt = 0; hirun = GAP + 1; hz = 0; rcnt = 0;
      sram_dq_i = 16'hBAD0;
    end else begin
      drive_now = !sram_ce_n && !sram_oe_n && sram_we_n && (sram_bl_n != 2'b11);
      if (!p_we && sram_we_n) begin
        chk(dstab >= SETUP_CYC, "R5 data setup before write end", 32'(dstab), 32'(SETUP_CYC));
        chk(ccnt >= PULSE_CYC, "R4 select width before write end", 32'(ccnt), 32'(PULSE_CYC));
        chk(sram_dq_oe && sram_dq_o == p_dq, "R5 data hold after write end",
            {15'd0, sram_dq_oe, sram_dq_o}, {15'd0, 1'b1, p_dq});
        if (!p_bl[0]) mem[p_addr[9:0]][7:0]  = p_dq[7:0];
        if (!p_bl[1]) mem[p_addr[9:0]][15:8] = p_dq[15:8];
        last_waddr = p_addr;
        n_writes++;
      end
      if (sram_dq_oe && (drive_now || hz != 0))
        chk(1'b0, "R5 bus contention", 32'(hz), 32'd0);
      if (p_ce && !sram_ce_n)
        chk(hirun >= GAP + 1, "R7 idle gap between accesses", 32'(hirun), 32'(GAP + 1));
      hirun = sram_ce_n ? hirun + 1 : 0;
      ccnt  = !sram_ce_n ? ccnt + 1 : 0;
      dstab = sram_dq_oe ? ((p_dqoe && sram_dq_o == p_dq) ? dstab + 1 : 1) : 0;
      hz    = drive_now ? HZ_CYC : (hz != 0 ? hz - 1 : 0);
      rcnt  = drive_now ? ((p_drv && sram_addr == p_addr) ? rcnt + 1 : 1) : 0;
      if (rcnt >= ACC_CYC)
        sram_dq_i = {sram_bl_n[1] ? 8'hEE : mem[sram_addr[9:0]][15:8],
                     sram_bl_n[0] ? 8'hEE : mem[sram_addr[9:0]][7:0]};
      else
        sram_dq_i = 16'hBAD0;
      p_ce = sram_ce_n; p_we = sram_we_n; p_dqoe = sram_dq_oe; p_drv = drive_now;
      p_bl = sram_bl_n; p_addr = sram_addr; p_dq = sram_dq_o;
    end
  end

  // strobes seen in the first cycle of the last access
  logic       s_ce, s_we, s_oe;
  logic [1:0] s_bl;

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [1:0] be,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                        output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    s_ce = sram_ce_n; s_we = sram_we_n; s_oe = sram_oe_n; s_bl = sram_bl_n;
    lat = 1;
    while (!rsp_ack && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (wr) begin
      if (be[0]) gold[a[9:0]][7:0]  = wd[7:0];
      if (be[1]) gold[a[9:0]][15:8] = wd[15:8];
    end
  endtask

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic t_reset;
    chk(sram_ce_n && sram_we_n && sram_oe_n && sram_bl_n == 2'b11,
        "R1 strobes high at reset", {sram_ce_n, sram_we_n, sram_oe_n, sram_bl_n}, 5'h1F);
    chk(!sram_dq_oe, "R1 drive enable low at reset", 32'(sram_dq_oe), 0);
    chk(req_ready && !rsp_ack, "R1 ready high ack low", {req_ready, rsp_ack}, 2'b10);
  endtask

  task automatic t_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] rd;
    int lat;
    access(1'b1, a, 2'b11, d, rd, lat);
    chk(lat == WR + HOLD + 1, "R8 write ack latency", 32'(lat), 32'(WR + HOLD + 1));
    chk(!s_ce && !s_we && s_oe, "R4 write strobes", {s_ce, s_we, s_oe}, 3'b001);
    chk(last_waddr == a, "R4 write address", 32'(last_waddr), 32'(a));
    access(1'b0, a, 2'b11, 16'h0, rd, lat);
    chk(lat == RD + 1, "R8 read ack latency", 32'(lat), 32'(RD + 1));
    chk(!s_ce && s_we && !s_oe, "R3 read strobes", {s_ce, s_we, s_oe}, 3'b010);
    chk(rd == gold[a[9:0]], "R3 read data", 32'(rd), 32'(gold[a[9:0]]));
  endtask

  task automatic t_lane_write(input logic [AW-1:0] a, input logic [1:0] be,
                              input logic [DW-1:0] d);
    logic [DW-1:0] rd;
    int lat;
    access(1'b1, a, be, d, rd, lat);
    chk(s_bl == ~be, "R6 lane strobes on write", 32'(s_bl), 32'(~be));
    access(1'b0, a, 2'b11, 16'h0, rd, lat);
    chk(rd == gold[a[9:0]], "R6 untouched lane kept", 32'(rd), 32'(gold[a[9:0]]));
  endtask

  task automatic t_lane_read(input logic [AW-1:0] a, input logic [1:0] be);
    logic [DW-1:0] rd;
    int lat;
    access(1'b0, a, be, 16'h0, rd, lat);
    chk(s_bl == ~be, "R6 lane strobes on read", 32'(s_bl), 32'(~be));
    chk((rd & lane_mask(be)) == (gold[a[9:0]] & lane_mask(be)), "R6 selected lane data",
        32'(rd & lane_mask(be)), 32'(gold[a[9:0]] & lane_mask(be)));
  endtask

  task automatic t_busy(input logic [AW-1:0] a, input logic [AW-1:0] other);
    int w0, lat;
    bit ok;
    w0 = n_writes;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = 2'b11; req_wdata = 16'h1357;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1'b0; req_addr = other;
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (req_ready || sram_addr != a || sram_we_n) ok = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(ok, "R2 command ignored while busy", 32'(sram_addr), 32'(a));
    lat = 0;
    while (!rsp_ack && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    gold[a[9:0]] = 16'h1357;
    repeat (4) @(negedge clk);
    chk(n_writes - w0 == 1 && sram_ce_n, "R2 only one access started",
        32'(n_writes - w0), 32'd1);
  endtask

  task automatic t_turnaround(input logic [AW-1:0] a);
    logic [DW-1:0] rd;
    int lat;
    access(1'b1, a, 2'b11, 16'hC0DE, rd, lat);
    access(1'b0, a, 2'b11, 16'h0, rd, lat);
    chk(rd == 16'hC0DE, "R7 read right after write", 32'(rd), 32'hC0DE);
  endtask

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset;
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_word(18'h30005, 16'hA5C3);
    t_word(18'h00000, 16'h0F0F);
    t_word(18'h3FFFF, 16'hFFFF);
    t_lane_write(18'h00012, 2'b01, 16'h7788);
    t_lane_write(18'h00013, 2'b10, 16'h99AA);
    t_lane_read(18'h00012, 2'b01);
    t_lane_read(18'h00013, 2'b10);
    t_busy(18'h00020, 18'h00021);
    t_turnaround(18'h00040);
    t_word(18'h15555, 16'h5AA5);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule